// File: doc/BRIEF.md
# PIO timing count calculator

This block turns the timing needs of one drive into whole-clock counts for a programmable IDE timing generator. From the bus clock frequency in MHz and the setup, active and total cycle times in nanoseconds, it works out an address-setup count, a data-active count and a data-recovery count. It clamps each count to what the generator can hold, adjusts for the chip revision, and gives the register codes for those counts.

Two drives on a shared channel use one set of timing registers. For that case the caller sets the merge input and supplies the counts already chosen for the other drive. Each output then becomes the slower of the two values. A request starts with a one-cycle `start` pulse. All inputs are latched at that moment. Five divisions then run one after another through a single restoring divider. The results appear together with a one-cycle `done` pulse.

The controller is a state machine with seven states:
- `ST_IDLE` waits for `start`.
- `ST_PERIOD` divides 1000 by the frequency.
- `ST_SETUP`, `ST_ACTIVE` and `ST_CYCLE` take the ceiling of each time over the clock period.
- `ST_RECOV` takes the ceiling of the leftover recovery time over the clock period.
- `ST_FINISH` registers the clamped and encoded results and raises `done`.

The transitions are: start-accept (`ST_IDLE` to `ST_PERIOD`); divider-complete (each division state to the next, in the order listed); results-latched (`ST_FINISH` to `ST_IDLE`).

Top module: `pio_cnt_calc`

## Requirements
- R1: The clock period is floor(1000 / freq_mhz). The raw setup, active and cycle counts are ceil(time / period), each computed from its own input time.
- R2: The recovery time is cycle_ns - setup_ns - active_ns, taken as 0 if negative. The raw recovery count is the larger of ceil(recovery time / period) and (cycle count - setup count - active count), where the second value is taken as 0 if negative.
- R3: The active count and the recovery count are each raised to at least 2 before any later step.
- R4: If the recovery count exceeds 17, the excess over 17 is added to the active count and the recovery count becomes 17. After that, the active count is capped at 16.
- R5: When chip_rev is greater than 1, one is subtracted from the recovery count. For every revision the recovery count is then capped at 16.
- R6: The setup count is held in the range 1 to 5: 0 becomes 1, and anything above 5 becomes 5. setup_code encodes it as follows: 4 gives 2'b00, 3 gives 2'b10, 5 gives 2'b11, and 1 or 2 gives 2'b01.
- R7: With merge_en set at start, each of setup_cnt, active_cnt and recov_cnt is the maximum of this drive's final count and the matching peer input. With merge_en clear, the peer inputs have no effect.
- R8: drw_byte is {active_cnt[3:0], recov_cnt[3:0]}, so a count of 16 packs as 0.
- R9: A start pulse is accepted only while busy is low, and it latches every input. Later input changes and start pulses during a run have no effect. busy stays high for a bounded number of cycles, and done is a one-cycle pulse that marks valid outputs.
- R10: After reset, busy and done are low and every count and code output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse, accepted while idle |
| freq_mhz | input | FW (8) | Bus clock frequency in MHz, nonzero |
| setup_ns | input | TW (16) | Address setup time in ns |
| active_ns | input | TW (16) | Data active time in ns |
| cycle_ns | input | TW (16) | Total cycle time in ns |
| chip_rev | input | 2 | Chip revision code |
| merge_en | input | 1 | Merge with the peer drive's counts |
| peer_setup | input | 5 | Peer drive setup count |
| peer_active | input | 5 | Peer drive active count |
| peer_recov | input | 5 | Peer drive recovery count |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| setup_cnt | output | 5 | Final setup count |
| active_cnt | output | 5 | Final active count |
| recov_cnt | output | 5 | Final recovery count |
| setup_code | output | 2 | Encoded setup count |
| drw_byte | output | 8 | Packed active/recovery byte |

## Verification
Some checks hold on every cycle through the assertions. done is a single-cycle pulse, and a run stays under its fixed cycle bound. At each done pulse the final counts stay in their legal ranges. The setup code matches the setup count, merged outputs never fall below the peer counts, and on early revisions the recovery count never drops below 2. The exact arithmetic needs the bench's directed scenarios, which compare against values computed from the requirements: the rounding of each division, the spill of long recovery into the active phase, the revision step, the setup clamp, the merge choice, and the rejection of a second start during a run.

// File: rtl/pio_cnt_pkg.sv
package pio_cnt_pkg;

    // Width of every final count (values up to 17 before the last caps)
    localparam int CNT_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PERIOD,
        ST_SETUP,
        ST_ACTIVE,
        ST_CYCLE,
        ST_RECOV,
        ST_FINISH
    } calc_state_t;

endpackage

// File: rtl/pio_div.sv
module pio_div #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quot,
    output logic          done
);
    localparam int SW = $clog2(DW + 1);

    logic [DW:0]   rem;
    logic [DW-1:0] q;
    logic [DW-1:0] d;
    logic [SW-1:0] steps;
    logic          run;
    logic [DW:0]   shifted;
    logic          fits;

    // One quotient bit per cycle, restoring form
    assign shifted = {rem[DW-1:0], q[DW-1]};
    assign fits    = shifted >= {1'b0, d};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            q     <= '0;
            d     <= '0;
            steps <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else if (load) begin
            rem   <= '0;
            q     <= dividend;
            d     <= divisor;
            steps <= SW'(DW);
            run   <= 1'b1;
            done  <= 1'b0;
        end else if (run) begin
            rem   <= fits ? (shifted - {1'b0, d}) : shifted;
            q     <= {q[DW-2:0], fits};
            steps <= steps - 1'b1;
            run   <= (steps != SW'(1));
            done  <= (steps == SW'(1));
        end else begin
            done  <= 1'b0;
        end
    end

    assign quot = q;

    // R9
    div_done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(run));

endmodule

// File: rtl/pio_cnt_clamp.sv
module pio_cnt_clamp
    import pio_cnt_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic [DW-1:0]    s_raw,
    input  logic [DW-1:0]    a_raw,
    input  logic [DW-1:0]    c_raw,
    input  logic [DW-1:0]    r_raw,
    input  logic [1:0]       rev,
    input  logic             merge,
    input  logic [CNT_W-1:0] peer_s,
    input  logic [CNT_W-1:0] peer_a,
    input  logic [CNT_W-1:0] peer_r,
    output logic [CNT_W-1:0] setup_f,
    output logic [CNT_W-1:0] active_f,
    output logic [CNT_W-1:0] recov_f,
    output logic [1:0]       code_f,
    output logic [7:0]       byte_f
);
    localparam int XW = DW + 2;

    logic [XW-1:0]    sum_sa, alt_r, rec0, rec_lo, act_lo, act_sp, rec_sp;
    logic [CNT_W-1:0] act_cap, rec_rv, rec_cap, set_cl;

    always_comb begin
        // Second recovery estimate from whole-cycle counts (R2)
        sum_sa = XW'(s_raw) + XW'(a_raw);
        alt_r  = (XW'(c_raw) > sum_sa) ? (XW'(c_raw) - sum_sa) : '0;
        rec0   = (XW'(r_raw) > alt_r) ? XW'(r_raw) : alt_r;
        // Floors of two clocks (R3)
        rec_lo = (rec0 < XW'(2)) ? XW'(2) : rec0;
        act_lo = (XW'(a_raw) < XW'(2)) ? XW'(2) : XW'(a_raw);
        // Long recovery spills into the active phase (R4)
        if (rec_lo > XW'(17)) begin
            act_sp = act_lo + rec_lo - XW'(17);
            rec_sp = XW'(17);
        end else begin
            act_sp = act_lo;
            rec_sp = rec_lo;
        end
        act_cap = (act_sp > XW'(16)) ? CNT_W'(16) : act_sp[CNT_W-1:0];
        // Revision step and final cap (R5)
        rec_rv  = (rev > 2'd1) ? (rec_sp[CNT_W-1:0] - 1'b1) : rec_sp[CNT_W-1:0];
        rec_cap = (rec_rv > CNT_W'(16)) ? CNT_W'(16) : rec_rv;
        // Setup range 1..5 (R6)
        if (s_raw == '0)
            set_cl = CNT_W'(1);
        else if (s_raw > DW'(5))
            set_cl = CNT_W'(5);
        else
            set_cl = s_raw[CNT_W-1:0];
        // Shared channel keeps the slower value (R7)
        setup_f  = (merge && peer_s > set_cl)  ? peer_s : set_cl;
        active_f = (merge && peer_a > act_cap) ? peer_a : act_cap;
        recov_f  = (merge && peer_r > rec_cap) ? peer_r : rec_cap;
        case (setup_f)
            CNT_W'(4): code_f = 2'b00;
            CNT_W'(3): code_f = 2'b10;
            CNT_W'(5): code_f = 2'b11;
            default:   code_f = 2'b01;
        endcase
        // R8
        byte_f = {active_f[3:0], recov_f[3:0]};
    end

endmodule

// File: rtl/pio_cnt_calc.sv
module pio_cnt_calc
    import pio_cnt_pkg::*;
#(
    parameter int FW = 8,
    parameter int TW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FW-1:0]    freq_mhz,
    input  logic [TW-1:0]    setup_ns,
    input  logic [TW-1:0]    active_ns,
    input  logic [TW-1:0]    cycle_ns,
    input  logic [1:0]       chip_rev,
    input  logic             merge_en,
    input  logic [CNT_W-1:0] peer_setup,
    input  logic [CNT_W-1:0] peer_active,
    input  logic [CNT_W-1:0] peer_recov,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] setup_cnt,
    output logic [CNT_W-1:0] active_cnt,
    output logic [CNT_W-1:0] recov_cnt,
    output logic [1:0]       setup_code,
    output logic [7:0]       drw_byte
);
    localparam int DW       = TW + 2;
    localparam int BUSY_MAX = 5 * (DW + 2) + 4;
    localparam int BCW      = $clog2(BUSY_MAX + 2);

    calc_state_t st, st_nx;

    logic [FW-1:0]    l_freq;
    logic [TW-1:0]    l_setup, l_active, l_cycle;
    logic [1:0]       l_rev;
    logic             l_merge;
    logic [CNT_W-1:0] l_ps, l_pa, l_pr;
    logic [DW-1:0]    per_q, s_q, a_q, c_q, r_q;
    logic             kick;
    logic [DW-1:0]    dvd, dvs, quot;
    logic             div_done;
    logic [DW-1:0]    sa_sum, rec_ns;
    logic             advance;
    logic [CNT_W-1:0] s_f, a_f, r_f;
    logic [1:0]       code_f;
    logic [7:0]       byte_f;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start)    st_nx = ST_PERIOD;
            ST_PERIOD: if (div_done) st_nx = ST_SETUP;
            ST_SETUP:  if (div_done) st_nx = ST_ACTIVE;
            ST_ACTIVE: if (div_done) st_nx = ST_CYCLE;
            ST_CYCLE:  if (div_done) st_nx = ST_RECOV;
            ST_RECOV:  if (div_done) st_nx = ST_FINISH;
            ST_FINISH:               st_nx = ST_IDLE;
        endcase
    end

    assign advance = (st != st_nx);

    // Divider operand selection: ceiling via (t + p - 1) / p
    assign sa_sum = DW'(l_setup) + DW'(l_active);
    assign rec_ns = (DW'(l_cycle) > sa_sum) ? (DW'(l_cycle) - sa_sum) : '0;

    always_comb begin
        dvs = per_q;
        unique case (st)
            ST_PERIOD: begin dvd = DW'(1000);                     dvs = DW'(l_freq); end
            ST_SETUP:  dvd = DW'(l_setup)  + per_q - 1'b1;
            ST_ACTIVE: dvd = DW'(l_active) + per_q - 1'b1;
            ST_CYCLE:  dvd = DW'(l_cycle)  + per_q - 1'b1;
            ST_RECOV:  dvd = rec_ns        + per_q - 1'b1;
            default:   dvd = '0;
        endcase
    end

    pio_div #(.DW(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (kick),
        .dividend (dvd),
        .divisor  (dvs),
        .quot     (quot),
        .done     (div_done)
    );

    pio_cnt_clamp #(.DW(DW)) u_clamp (
        .s_raw    (s_q),
        .a_raw    (a_q),
        .c_raw    (c_q),
        .r_raw    (r_q),
        .rev      (l_rev),
        .merge    (l_merge),
        .peer_s   (l_ps),
        .peer_a   (l_pa),
        .peer_r   (l_pr),
        .setup_f  (s_f),
        .active_f (a_f),
        .recov_f  (r_f),
        .code_f   (code_f),
        .byte_f   (byte_f)
    );

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {l_freq, l_setup, l_active, l_cycle, l_rev, l_merge} <= '0;
            {l_ps, l_pa, l_pr}                 <= '0;
            {per_q, s_q, a_q, c_q, r_q}        <= '0;
            kick       <= 1'b0;
            done       <= 1'b0;
            setup_cnt  <= '0;
            active_cnt <= '0;
            recov_cnt  <= '0;
            setup_code <= '0;
            drw_byte   <= '0;
        end else begin
            kick <= advance && (st != ST_RECOV) && (st != ST_FINISH);
            done <= (st == ST_FINISH);
            if (st == ST_IDLE && start) begin
                l_freq   <= freq_mhz;
                l_setup  <= setup_ns;
                l_active <= active_ns;
                l_cycle  <= cycle_ns;
                l_rev    <= chip_rev;
                l_merge  <= merge_en;
                l_ps     <= peer_setup;
                l_pa     <= peer_active;
                l_pr     <= peer_recov;
            end
            if (div_done) begin
                unique case (st)
                    ST_PERIOD: per_q <= quot;
                    ST_SETUP:  s_q   <= quot;
                    ST_ACTIVE: a_q   <= quot;
                    ST_CYCLE:  c_q   <= quot;
                    ST_RECOV:  r_q   <= quot;
                    default: ;
                endcase
            end
            if (st == ST_FINISH) begin
                setup_cnt  <= s_f;
                active_cnt <= a_f;
                recov_cnt  <= r_f;
                setup_code <= code_f;
                drw_byte   <= byte_f;
            end
        end
    end

    assign busy = (st != ST_IDLE);

    // Cycle counter for the latency bound
    logic [BCW-1:0] busy_cycles;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cycles <= '0;
        else if (busy) busy_cycles <= busy_cycles + 1'b1;
        else           busy_cycles <= '0;
    end

    // R9
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cycles <= BCW'(BUSY_MAX));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    active_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !l_merge |-> (active_cnt >= 2) && (active_cnt <= 16));
    // R5
    recov_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !l_merge && (l_rev <= 2'd1) |-> (recov_cnt >= 2) && (recov_cnt <= 16));
    // R6
    setup_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((setup_cnt == 5'd4) == (setup_code == 2'b00)) && (setup_cnt >= 1));
    // R7
    merge_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && l_merge |-> (setup_cnt >= l_ps) && (active_cnt >= l_pa) && (recov_cnt >= l_pr));

endmodule

// File: tb/pio_cnt_calc_test.sv
module pio_cnt_calc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] freq_mhz = '0;
    logic [15:0] setup_ns = '0, active_ns = '0, cycle_ns = '0;
    logic [1:0] chip_rev = '0;
    logic       merge_en = 1'b0;
    logic [4:0] peer_setup = '0, peer_active = '0, peer_recov = '0;
    logic       busy, done;
    logic [4:0] setup_cnt, active_cnt, recov_cnt;
    logic [1:0] setup_code;
    logic [7:0] drw_byte;

    int n_checks = 0;
    int n_fail   = 0;
    int e_s, e_a, e_r, e_code, e_byte;

    always #4 clk = ~clk;

    pio_cnt_calc uut (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_mhz(freq_mhz),
        .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns),
        .chip_rev(chip_rev), .merge_en(merge_en), .peer_setup(peer_setup),
        .peer_active(peer_active), .peer_recov(peer_recov), .busy(busy),
        .done(done), .setup_cnt(setup_cnt), .active_cnt(active_cnt),
        .recov_cnt(recov_cnt), .setup_code(setup_code), .drw_byte(drw_byte)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Expected values from the requirements
    task automatic model(input int f, input int ts, input int ta, input int tc,
                         input int rev, input bit mg, input int ps, input int pa, input int pr);
        int p, s, a, c, rt, r1, r2, r;
        p  = 1000 / f;                                   // R1
        s  = (ts + p - 1) / p;
        a  = (ta + p - 1) / p;
        c  = (tc + p - 1) / p;
        rt = tc - ts - ta; if (rt < 0) rt = 0;           // R2
        r1 = (rt + p - 1) / p;
        r2 = c - s - a; if (r2 < 0) r2 = 0;
        r  = (r1 > r2) ? r1 : r2;
        if (r < 2) r = 2;                                // R3
        if (a < 2) a = 2;
        if (r > 17) begin a = a + r - 17; r = 17; end    // R4
        if (a > 16) a = 16;
        if (rev > 1) r = r - 1;                          // R5
        if (r > 16) r = 16;
        if (s < 1) s = 1;                                // R6
        if (s > 5) s = 5;
        if (mg) begin                                    // R7
            if (ps > s) s = ps;
            if (pa > a) a = pa;
            if (pr > r) r = pr;
        end
        e_s = s; e_a = a; e_r = r;
        e_code = (s == 4) ? 0 : (s == 3) ? 2 : (s == 5) ? 3 : 1;
        e_byte = ((a & 15) << 4) | (r & 15);             // R8
    endtask

    task automatic apply(input int f, input int ts, input int ta, input int tc,
                         input int rev, input bit mg, input int ps, input int pa, input int pr);
        freq_mhz = 8'(f); setup_ns = 16'(ts); active_ns = 16'(ta); cycle_ns = 16'(tc);
        chip_rev = 2'(rev); merge_en = mg;
        peer_setup = 5'(ps); peer_active = 5'(pa); peer_recov = 5'(pr);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        check("R9 done seen", int'(done), 1);
    endtask

    task automatic compare(input string tag);
        check({tag, " setup"},  setup_cnt,  e_s);
        check({tag, " active"}, active_cnt, e_a);
        check({tag, " recov"},  recov_cnt,  e_r);
        check({tag, " code"},   setup_code, e_code);
        check({tag, " byte"},   drw_byte,   e_byte);
    endtask

    task automatic run_case(input string tag, input int f, input int ts, input int ta,
                            input int tc, input int rev, input bit mg,
                            input int ps, input int pa, input int pr);
        model(f, ts, ta, tc, rev, mg, ps, pa, pr);
        @(negedge clk);
        apply(f, ts, ta, tc, rev, mg, ps, pa, pr);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 busy after start", int'(busy), 1);
        wait_done();
        compare(tag);
        @(negedge clk);
        check("R9 done one cycle", int'(done), 0);
    endtask

    task automatic test_reset();
        check("R10 busy", int'(busy), 0);
        check("R10 done", int'(done), 0);
        check("R10 counts", int'({setup_cnt, active_cnt, recov_cnt}), 0);
        check("R10 code/byte", int'({setup_code, drw_byte}), 0);
    endtask

    task automatic test_restart_ignored();
        int extra = 0;
        model(33, 70, 165, 600, 1, 1'b0, 0, 0, 0);
        @(negedge clk);
        apply(33, 70, 165, 600, 1, 1'b0, 0, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        apply(200, 5, 5, 20, 3, 1'b1, 5, 16, 16);     // must not be taken
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        compare("R9 restart ignored");
        repeat (40) begin @(negedge clk); if (done) extra++; end
        check("R9 no second result", extra, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        // R1 R2: typical slow drive on an early revision
        run_case("R1 slow rev1", 33, 70, 165, 600, 1, 1'b0, 0, 0, 0);
        // R5: same timing, later revision
        run_case("R5 slow rev2", 33, 70, 165, 600, 2, 1'b0, 0, 0, 0);
        // R3: fast timing raised to floor, then revision step
        run_case("R3 fast floor", 33, 25, 70, 120, 2, 1'b0, 0, 0, 0);
        // R4: long recovery spills into active
        run_case("R4 spill", 50, 20, 60, 460, 2, 1'b0, 0, 0, 0);
        // R4: spill saturates active, recovery capped
        run_case("R4 saturate", 50, 20, 40, 800, 1, 1'b0, 0, 0, 0);
        // R2: negative recovery time
        run_case("R2 negative", 33, 100, 200, 150, 1, 1'b0, 0, 0, 0);
        // R6: setup above 5 clamps
        run_case("R6 setup clamp", 66, 100, 30, 300, 1, 1'b0, 0, 0, 0);
        // R6: zero times, slowest clock
        run_case("R6 zero times", 1, 0, 0, 0, 3, 1'b0, 0, 0, 0);
        // R7: merge with slower peer
        run_case("R7 merge on", 33, 70, 165, 600, 1, 1'b1, 5, 4, 15);
        // R7: peers ignored without merge
        run_case("R7 merge off", 33, 70, 165, 600, 1, 1'b0, 5, 16, 16);
        // R8: sixteen packs as zero
        run_case("R8 pack", 100, 10, 300, 1000, 1, 1'b0, 0, 0, 0);
        test_restart_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule